// File: doc/BRIEF.md
# Single-Channel PWM Timer with Buffered Period and Compare

This block is one channel of a general-purpose timer that produces a pulse-width modulated output. A 16-bit counter runs against a period value, and a compare value decides where in each period the reference waveform switches. Software writes the period and compare values through a small register write port. Both values land in buffer registers and reach the active copies used by the counter and the comparator only at an update event. An update event occurs either when the counter turns around at the end of a period or when software forces one. A forced update is the normal way to load the first values before the counter is started.

The counter counts up with edge alignment, counts down with edge alignment, or counts up and down with center alignment. The channel is either frozen, in which case the reference holds its value, or in one of two PWM modes that are logical inverses of each other. A polarity bit and an enable bit shape the reference into the pin value. Control and channel settings take effect on the cycle after they are written. Only the period and compare values wait for an update event.

Register write port (`wr_addr`): 0 control (bit 0 run, bit 1 count down, bits 3:2 alignment with 00 for edge and any other value for center), 1 period buffer, 2 compare buffer, 3 channel (bits 2:0 mode, bit 3 polarity, bit 4 output enable), 4 force update (the data is ignored).

Top module: `pwm_timer_top`

## Requirements
- R1: After a clock edge with `rst_n` low, `count_out` is 0, `ref_out` is 0, `pwm_out` is 0 and `update_evt` is 0. Both buffers and both active values are 0, and the channel mode is frozen.
- R2: A write to the period buffer (address 1) or the compare buffer (address 2) does not change the counter's turnaround point or the reference waveform until the next update event. This holds whether the counter is running or stopped.
- R3: A write to address 4 raises `update_evt` in that cycle and copies both buffers into the active values at that edge. It also restarts the counter: at 0 (counting upward, with center alignment in its rising phase), or at the new period value for edge-aligned down-counting.
- R4: With run=1, alignment 00 and count-down=0, the counter steps up by 1 each cycle. In the cycle where it equals the active period it raises `update_evt`, and it becomes 0 at the next edge.
- R5: With run=1, alignment 00 and count-down=1, the counter steps down by 1 each cycle. In the cycle where it equals 0 it raises `update_evt`, and it is reloaded with the active period at the next edge.
- R6: With run=1 and a nonzero alignment, the counter rises to the active period and then falls to 0. It raises `update_evt` in each cycle that holds a turning value (period or 0). With a period of P it repeats every 2P cycles.
- R7: In mode 3'b110 (PWM 1), `ref_out` is registered: after each edge it equals 1 when the counter value before that edge was less than the active compare value, and 0 otherwise.
- R8: In mode 3'b111 (PWM 2), `ref_out` after each edge is the inverse of what PWM 1 would give for the same counter and compare values.
- R9: A compare value greater than the period keeps `ref_out` at 1 in PWM 1, and a compare value of 0 keeps it at 0.
- R10: In mode 3'b000 (frozen) and any other mode code, `ref_out` holds its last value. Switching back to a PWM mode resumes the comparison at the next edge.
- R11: `pwm_out` equals `ref_out` when polarity is 0, equals its inverse when polarity is 1, and is 0 whenever output enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | Output pin after polarity and enable |
| ref_out | output | 1 | Reference waveform before polarity and enable |
| count_out | output | 16 | Current counter value |
| update_evt | output | 1 | Update event pulse (turnaround or forced) |

## Verification
The hardest situation to reach from the ports is a buffer write that lands in the middle of a running period. The old compare or period value must still govern the rest of that period, and the new value must take over only after the turnaround. The bench waits until it observes a known counter value, writes the buffer a fixed number of cycles before the compare point, and samples the reference at a counter value where the old and new compare values disagree, both before and after the next wrap. A shortened period is checked the same way: the bench confirms that the counter still passes the new limit before the first update event and stays within it afterwards.

// File: rtl/pwm_timer_pkg.sv
// Package: shared encodings and types for the PWM timer.
// Assumes a 3-bit register address space and 16-bit data words.
package pwm_timer_pkg;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_PERIOD = 3'd1;
    localparam logic [2:0] ADDR_CMP    = 3'd2;
    localparam logic [2:0] ADDR_CHAN   = 3'd3;
    localparam logic [2:0] ADDR_FORCE  = 3'd4;

    localparam logic [2:0] MODE_FROZEN = 3'b000;
    localparam logic [2:0] MODE_PWM1   = 3'b110;
    localparam logic [2:0] MODE_PWM2   = 3'b111;

    typedef struct packed {
        logic [1:0] align;   // 00 edge, otherwise center
        logic       down;    // edge-aligned direction
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic       oe;
        logic       pol;     // 1 inverts the reference at the pin
        logic [2:0] mode;
    } chan_t;

endpackage

// File: rtl/pwm_regs.sv
// Module: register file of the timer. Control and channel fields apply
// at once; period and compare go to buffers and are copied to the active
// values only on an update event. Assumes a single write per cycle.
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         upd_evt,
    output ctrl_t        ctrl,
    output chan_t        chan,
    output logic [W-1:0] per_buf,
    output logic [W-1:0] per_act,
    output logic [W-1:0] cmp_act,
    output logic         force_upd
);

    logic [W-1:0] cmp_buf;
    logic         unused_hi;

    assign unused_hi = ^wr_data[W-1:5];

    // Decode the software-forced update command.
    assign force_upd = wr_en && (wr_addr == ADDR_FORCE);

    // Capture software writes into control, channel and buffer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            chan    <= '0;
            per_buf <= '0;
            cmp_buf <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:   ctrl    <= ctrl_t'(wr_data[3:0]);
                ADDR_PERIOD: per_buf <= wr_data;
                ADDR_CMP:    cmp_buf <= wr_data;
                ADDR_CHAN:   chan    <= chan_t'(wr_data[4:0]);
                default: ;
            endcase
        end
    end

    // Move buffers to active copies on update events only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act <= '0;
            cmp_act <= '0;
        end else if (upd_evt) begin
            per_act <= per_buf;
            cmp_act <= cmp_buf;
        end
    end

    // R2: active values are untouched without an update event.
    a_r2_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |=> ($stable(per_act) && $stable(cmp_act)));

    // R3: an update event loads exactly the buffered values.
    a_r3_active_load: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> (per_act == $past(per_buf) && cmp_act == $past(cmp_buf)));

endmodule

// File: rtl/pwm_counter.sv
// Module: timebase counter for edge-aligned up, edge-aligned down and
// center-aligned counting. Flags a turnaround as wrap_evt. A forced update
// restarts the count. Assumes the active period is stable between updates.
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] per_act,
    input  logic [W-1:0] per_buf,
    input  logic         force_upd,
    output logic [W-1:0] cnt,
    output logic         wrap_evt
);

    logic         center;
    logic         falling;
    logic         falling_nxt;
    logic [W-1:0] cnt_nxt;

    assign center = (ctrl.align != 2'b00);

    // Next count, direction and turnaround for the selected mode.
    always_comb begin
        cnt_nxt     = cnt;
        falling_nxt = falling;
        wrap_evt    = 1'b0;
        if (ctrl.run) begin
            if (!center) begin
                if (!ctrl.down) begin
                    if (cnt >= per_act) begin
                        cnt_nxt  = '0;
                        wrap_evt = 1'b1;
                    end else begin
                        cnt_nxt = W'(cnt + 1'b1);
                    end
                end else begin
                    if (cnt == '0) begin
                        cnt_nxt  = per_act;
                        wrap_evt = 1'b1;
                    end else begin
                        cnt_nxt = W'(cnt - 1'b1);
                    end
                end
            end else if (!falling) begin
                if (cnt >= per_act) begin
                    wrap_evt    = 1'b1;
                    falling_nxt = 1'b1;
                    cnt_nxt     = (cnt == '0) ? '0 : W'(cnt - 1'b1);
                end else begin
                    cnt_nxt = W'(cnt + 1'b1);
                end
            end else begin
                if (cnt == '0) begin
                    wrap_evt    = 1'b1;
                    falling_nxt = 1'b0;
                    cnt_nxt     = (per_act == '0) ? '0 : W'(1);
                end else begin
                    cnt_nxt = W'(cnt - 1'b1);
                end
            end
        end
        if (force_upd) begin
            cnt_nxt     = (!center && ctrl.down) ? per_buf : '0;
            falling_nxt = 1'b0;
        end
    end

    // Register the count and the center-aligned phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            falling <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            falling <= falling_nxt;
        end
    end

    // R4: edge-aligned up-counting steps by one below the period.
    a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && !center && !ctrl.down && !force_upd && cnt < per_act)
        |=> cnt == $past(cnt) + 1'b1);

    // R5: edge-aligned down-counting reloads the period after zero.
    a_r5_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && !center && ctrl.down && !force_upd && cnt == '0)
        |=> cnt == $past(per_act));

    // R6: center-aligned counting turns downward at the period.
    a_r6_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && center && !falling && !force_upd && cnt >= per_act && cnt != '0)
        |=> cnt < $past(cnt));

    // R3: a forced update in up-counting restarts at zero.
    a_r3_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (force_upd && !ctrl.down) |=> cnt == '0);

endmodule

// File: rtl/pwm_compare.sv
// Module: compare stage producing the registered PWM reference. Assumes
// the counter and active compare value come from the same clock domain.
module pwm_compare
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_act,
    output logic         ref_q
);

    logic below;

    assign below = (cnt < cmp_act);

    // Update the reference in PWM modes; hold it in every other mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else begin
            case (mode)
                MODE_PWM1: ref_q <= below;
                MODE_PWM2: ref_q <= !below;
                default:   ref_q <= ref_q;
            endcase
        end
    end

    // R10: non-PWM modes freeze the reference.
    a_r10_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_PWM1 && mode != MODE_PWM2) |=> $stable(ref_q));

    // R9: a zero compare value keeps PWM 1 low.
    a_r9_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM1 && cmp_act == '0) |=> !ref_q);

    // R8: a zero compare value keeps PWM 2 high.
    a_r8_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM2 && cmp_act == '0) |=> ref_q);

endmodule

// File: rtl/pwm_timer_top.sv
// Module: single-channel PWM timer top. Connects the register file,
// the counter and the compare stage, and shapes the pin with polarity and
// enable. Assumes synchronous software writes on the same clock.
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out,
    output logic         ref_out,
    output logic [W-1:0] count_out,
    output logic         update_evt
);

    ctrl_t        ctrl;
    chan_t        chan;
    logic [W-1:0] per_buf;
    logic [W-1:0] per_act;
    logic [W-1:0] cmp_act;
    logic         force_upd;
    logic         wrap_evt;
    logic [W-1:0] cnt;
    logic         ref_q;

    // Combine counter turnarounds and software-forced updates.
    assign update_evt = wrap_evt | force_upd;

    pwm_regs #(.W(W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .upd_evt   (update_evt),
        .ctrl      (ctrl),
        .chan      (chan),
        .per_buf   (per_buf),
        .per_act   (per_act),
        .cmp_act   (cmp_act),
        .force_upd (force_upd)
    );

    pwm_counter #(.W(W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .per_act   (per_act),
        .per_buf   (per_buf),
        .force_upd (force_upd),
        .cnt       (cnt),
        .wrap_evt  (wrap_evt)
    );

    pwm_compare #(.W(W)) cmp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (chan.mode),
        .cnt     (cnt),
        .cmp_act (cmp_act),
        .ref_q   (ref_q)
    );

    // Drive the pin from the reference through polarity and enable.
    assign pwm_out   = chan.oe & (ref_q ^ chan.pol);
    assign ref_out   = ref_q;
    assign count_out = cnt;

    // R11: with the output disabled the pin stays low across edges.
    a_r11_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 1'b0 && !chan.oe) |=> !pwm_out);

endmodule

// File: tb/pwm_timer_top_tb_top.sv
module pwm_timer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic        ref_out;
    logic [15:0] count_out;
    logic        update_evt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_timer_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .ref_out    (ref_out),
        .count_out  (count_out),
        .update_evt (update_evt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic window(input int n, output int high, output int upd,
                          output int maxc, output int pin_high, output int inv_err);
        high = 0; upd = 0; maxc = 0; pin_high = 0; inv_err = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            high += ref_out;
            upd += update_evt;
            pin_high += pwm_out;
            if (pwm_out != !ref_out) inv_err++;
            if (count_out > maxc) maxc = count_out;
        end
    endtask

    task automatic wait_count(input int v, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (count_out == v) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check(count_out == 0, "R1 count", count_out, 0);
        check(ref_out == 0, "R1 ref", ref_out, 0);
        check(pwm_out == 0, "R1 pin", pwm_out, 0);
        check(update_evt == 0, "R1 update", update_evt, 0);
    endtask

    task automatic t_buffered_stopped();
        int h, u, m, p, e;
        wr(3'd1, 16'd9);
        wr(3'd2, 16'd4);
        wr(3'd3, 16'h0016);
        window(5, h, u, m, p, e);
        check(h == 0, "R2 compare buffered while stopped", h, 0);
        wr(3'd4, 16'd0);
        window(3, h, u, m, p, e);
        check(h == 3, "R3 forced update loads compare", h, 3);
        check(m == 0, "R3 counter restart at 0", m, 0);
    endtask

    task automatic t_edge_up();
        int h, u, m, p, e;
        bit ok;
        wr(3'd0, 16'h0001);
        window(20, h, u, m, p, e);
        check(h == 8, "R7 high cycles per 20", h, 8);
        check(u == 2, "R4 update pulses per 20", u, 2);
        check(m == 9, "R4 max count", m, 9);
        wait_count(4, ok);
        check(ok && ref_out == 1, "R7 ref after count 3", ref_out, 1);
        wait_count(5, ok);
        check(ok && ref_out == 0, "R7 ref after count 4", ref_out, 0);
        wait_count(9, ok);
        check(ok && update_evt == 1, "R4 update at period", update_evt, 1);
        @(negedge clk);
        check(count_out == 0, "R4 wrap to 0", count_out, 0);
    endtask

    task automatic t_mid_period_writes();
        int h, u, m, p, e;
        bit ok;
        wait_count(1, ok);
        wr(3'd2, 16'd7);
        wait_count(6, ok);
        check(ok && ref_out == 0, "R2 old compare until update", ref_out, 0);
        wait_count(0, ok);
        wait_count(6, ok);
        check(ok && ref_out == 1, "R2 new compare after update", ref_out, 1);
        wait_count(1, ok);
        wr(3'd1, 16'd5);
        wait_count(8, ok);
        check(ok, "R2 old period until update", ok, 1);
        wait_count(0, ok);
        window(12, h, u, m, p, e);
        check(m == 5, "R2 new period after update", m, 5);
        check(u == 2, "R4 updates with period 5", u, 2);
        wr(3'd1, 16'd9);
        wr(3'd4, 16'd0);
    endtask

    task automatic t_pwm2();
        int h, u, m, p, e;
        wr(3'd3, 16'h0017);
        window(20, h, u, m, p, e);
        check(h == 6, "R8 PWM2 high cycles", h, 6);
    endtask

    task automatic t_saturation();
        int h, u, m, p, e;
        wr(3'd3, 16'h0016);
        wr(3'd2, 16'd12);
        wr(3'd4, 16'd0);
        window(20, h, u, m, p, e);
        check(h == 20, "R9 compare above period stays high", h, 20);
        wr(3'd2, 16'd0);
        wr(3'd4, 16'd0);
        window(20, h, u, m, p, e);
        check(h == 0, "R9 compare zero stays low", h, 0);
    endtask

    task automatic t_polarity();
        int h, u, m, p, e;
        wr(3'd2, 16'd4);
        wr(3'd4, 16'd0);
        wr(3'd3, 16'h001E);
        window(20, h, u, m, p, e);
        check(e == 0, "R11 inverted pin mismatches", e, 0);
        check(p == 12, "R11 inverted pin high cycles", p, 12);
        wr(3'd3, 16'h0006);
        window(20, h, u, m, p, e);
        check(p == 0, "R11 disabled pin high cycles", p, 0);
        check(h == 8, "R11 reference still runs when disabled", h, 8);
    endtask

    task automatic t_frozen();
        int h, u, m, p, e;
        bit ok;
        wr(3'd3, 16'h0016);
        wait_count(2, ok);
        wr(3'd3, 16'h0010);
        window(20, h, u, m, p, e);
        check(h == 20, "R10 frozen holds high", h, 20);
        wr(3'd3, 16'h0016);
        window(20, h, u, m, p, e);
        check(h == 8, "R10 PWM resumes after frozen", h, 8);
    endtask

    task automatic t_down();
        int h, u, m, p, e;
        bit ok;
        wr(3'd0, 16'h0003);
        window(20, h, u, m, p, e);
        check(u == 2, "R5 update pulses per 20", u, 2);
        check(m == 9, "R5 max count", m, 9);
        wait_count(5, ok);
        @(negedge clk);
        check(count_out == 4, "R5 step down", count_out, 4);
        wait_count(0, ok);
        check(ok && update_evt == 1, "R5 update at zero", update_evt, 1);
        @(negedge clk);
        check(count_out == 9, "R5 reload period", count_out, 9);
    endtask

    task automatic t_center();
        int h, u, m, p, e;
        bit ok;
        wr(3'd1, 16'd4);
        wr(3'd0, 16'h0005);
        wr(3'd4, 16'd0);
        window(16, h, u, m, p, e);
        check(u == 4, "R6 turning-point updates per 16", u, 4);
        check(m == 4, "R6 max count", m, 4);
        wait_count(4, ok);
        @(negedge clk);
        check(count_out == 3, "R6 turn down at period", count_out, 3);
        wait_count(0, ok);
        check(ok && update_evt == 1, "R6 update at zero", update_evt, 1);
        @(negedge clk);
        check(count_out == 1, "R6 turn up at zero", count_out, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_buffered_stopped();
        t_edge_up();
        t_mid_period_writes();
        t_pwm2();
        t_saturation();
        t_polarity();
        t_frozen();
        t_down();
        t_center();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule